// File: doc/BRIEF.md
# Accumulator ALU with Half-Carry Flags

This block is the arithmetic and logic datapath of a small 8-bit accumulator processor. It takes an operation code, two operands and the current flag byte. On each enabled clock edge it registers a result and a new flag byte. The flag byte carries four condition bits in its upper nibble: zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. The lower nibble always reads as zero. Half-carry is the carry or borrow across the nibble boundary: bit 3 to bit 4 for byte operations, and bit 11 to bit 12 for the wide additions.

Byte operations use the low byte of each operand and return their result in the low byte with the upper byte cleared. Two 16-bit operations are also supported. The first adds a register pair to a 16-bit value. The second adds a sign-extended 8-bit offset to a stack pointer. Each operation group either forwards the incoming zero and carry bits unchanged or forces them, as the requirements below list. The register file and decimal adjust live outside this block.

Top module: `nib_alu`

## Requirements
- R1: A synchronous active-low reset clears `result_q` and `flags_q` to zero. While `en` is low, both outputs hold their values.
- R2: Add (code 0) returns a+b modulo 256. Z is set when that byte is zero. N is cleared. H is set on a carry out of bit 3, and C on a carry out of bit 7.
- R3: Subtract (code 2) and compare (code 4) set N. H is set on a borrow into bit 3 (low nibble of a below that of b), C on a borrow from bit 8 (a below b), and Z on a zero difference. Compare returns the unchanged low byte of a as its result.
- R4: Add-with-carry (code 1) and subtract-with-carry (code 3) first form b' = (b + C_in) mod 256, then act as add or subtract with b'. When b is 0xFF and C_in is 1, b' becomes zero.
- R5: Increment (code 8) and decrement (code 9) change a by one and pass C_in through to the output. Increment clears N and sets H when the result's low nibble is 0. Decrement sets N and sets H when the result's low nibble is 0xF.
- R6: AND (code 5) sets H and clears N and C. OR (code 6) and XOR (code 7) clear N, H and C. All three set Z from the result byte.
- R7: Complement (code 10) returns ~a, sets N and H, and keeps Z and C. Set-carry (code 11) and complement-carry (code 12) return a unchanged, keep Z and clear N and H. Set-carry forces C to 1; complement-carry inverts C.
- R8: Wide add (code 13) returns a+b modulo 65536. It keeps Z and clears N. H is set on a carry out of bit 11, and C on a carry out of bit 15.
- R9: Offset add (code 14) returns a plus the sign-extended low byte of b, modulo 65536. It clears Z and N. H and C are taken from the carries out of bit 11 and bit 15 of that 16-bit sum.
- R10: Bits 3..0 of `flags_q` are always zero, and bits 3..0 of `flags_in` have no effect on any output.
- R11: For codes 0 to 12 the upper byte of `result_q` is zero. Code 15 passes a through unchanged and returns the upper nibble of `flags_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Capture result and flags on this edge |
| op | input | 4 | Operation code (see R11 list in requirements) |
| opnd_a | input | 16 | First operand (accumulator, register pair or stack pointer) |
| opnd_b | input | 16 | Second operand (byte ops use the low byte) |
| flags_in | input | 8 | Current flag byte, Z/N/H/C in bits 7..4 |
| result_q | output | 16 | Registered result |
| flags_q | output | 8 | Registered new flag byte |

## Verification
The hardest cases to reach are the carry-folding wrap, where b is 0xFF and the incoming carry turns the second operand into zero, and the offset add with a negative offset, which must report a carry even though the pointer decreases. Directed operations with hand-chosen operands reach these cases, along with nibble-boundary values such as 0x0F/0x10 and 0x0FFF/0x1000. A long run of random codes, operands and incoming flags then follows. Every incoming flag byte in that run has a non-zero low nibble, so any leakage into the outputs would show.

// File: rtl/nib_alu_pkg.sv
// Shared definitions for the accumulator ALU: operation codes and the
// positions of the four condition bits inside the flag byte.
package nib_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADC   = 4'd1,
        OP_SUB   = 4'd2,
        OP_SBC   = 4'd3,
        OP_CMP   = 4'd4,
        OP_AND   = 4'd5,
        OP_OR    = 4'd6,
        OP_XOR   = 4'd7,
        OP_INC   = 4'd8,
        OP_DEC   = 4'd9,
        OP_CPL   = 4'd10,
        OP_SCF   = 4'd11,
        OP_CCF   = 4'd12,
        OP_ADDW  = 4'd13,
        OP_ADDSP = 4'd14,
        OP_PASS  = 4'd15
    } alu_op_e;

    localparam int FL_Z = 7;
    localparam int FL_N = 6;
    localparam int FL_H = 5;
    localparam int FL_C = 4;

endpackage

// File: rtl/nib_alu_arith8.sv
// Byte adder/subtractor: add, add-with-carry, subtract, subtract-with-carry,
// compare, increment and decrement. Purely combinational.
// Assumes op is one of those seven codes; other codes produce don't-care output.
module nib_alu_arith8
    import nib_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            c_in,
    output logic [DW-1:0]   res,
    output logic [7:0]      fl
);
    localparam int NIB = 4;

    logic          fold_c;
    logic          is_sub;
    logic          is_step;
    logic [DW-1:0] b_eff;
    logic [DW:0]   full;
    logic [NIB:0]  low;
    logic          z;
    logic          h;
    logic          c;

    // Form the effective second operand and the direction of the operation
    always_comb begin
        fold_c  = (op == OP_ADC) || (op == OP_SBC);
        is_step = (op == OP_INC) || (op == OP_DEC);
        is_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);
        if (is_step)
            b_eff = DW'(1);
        else
            b_eff = b + DW'(fold_c & c_in);
    end

    // Full-width and nibble-width sum or difference, then the flag byte
    always_comb begin
        if (is_sub) begin
            full = {1'b0, a} - {1'b0, b_eff};
            low  = {1'b0, a[NIB-1:0]} - {1'b0, b_eff[NIB-1:0]};
        end else begin
            full = {1'b0, a} + {1'b0, b_eff};
            low  = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]};
        end
        z   = (full[DW-1:0] == '0);
        h   = low[NIB];
        c   = is_step ? c_in : full[DW];
        res = (op == OP_CMP) ? a : full[DW-1:0];
        fl  = {z, is_sub, h, c, 4'b0000};
    end

endmodule

// File: rtl/nib_alu_logic8.sv
// Bitwise and flag-only operations: AND, OR, XOR, complement, set carry,
// complement carry, and the pass code. Purely combinational.
// Assumes op is one of those codes; arithmetic codes fall to the pass case.
module nib_alu_logic8
    import nib_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            z_in,
    input  logic            n_in,
    input  logic            h_in,
    input  logic            c_in,
    output logic [DW-1:0]   res,
    output logic [7:0]      fl
);
    // Select the result byte and the flags each code forces or keeps
    always_comb begin
        unique case (op)
            OP_AND: begin
                res = a & b;
                fl  = {res == '0, 1'b0, 1'b1, 1'b0, 4'b0000};
            end
            OP_OR: begin
                res = a | b;
                fl  = {res == '0, 3'b000, 4'b0000};
            end
            OP_XOR: begin
                res = a ^ b;
                fl  = {res == '0, 3'b000, 4'b0000};
            end
            OP_CPL: begin
                res = ~a;
                fl  = {z_in, 1'b1, 1'b1, c_in, 4'b0000};
            end
            OP_SCF: begin
                res = a;
                fl  = {z_in, 1'b0, 1'b0, 1'b1, 4'b0000};
            end
            OP_CCF: begin
                res = a;
                fl  = {z_in, 1'b0, 1'b0, ~c_in, 4'b0000};
            end
            default: begin
                res = a;
                fl  = {z_in, n_in, h_in, c_in, 4'b0000};
            end
        endcase
    end

endmodule

// File: rtl/nib_alu_wide16.sv
// Wide adder for register-pair add and stack-pointer offset add.
// In offset mode the low byte of b is sign-extended before the add.
// Half-carry is the carry out of bit WW-5 (bit 11 for a 16-bit word).
module nib_alu_wide16 #(
    parameter int DW = 8,
    parameter int WW = 16
) (
    input  logic            sp_mode,
    input  logic [WW-1:0]   a,
    input  logic [WW-1:0]   b,
    input  logic            z_in,
    output logic [WW-1:0]   res,
    output logic [7:0]      fl
);
    localparam int HB = WW - 4;

    logic [WW-1:0] addend;
    logic [WW:0]   full;
    logic [HB:0]   part;

    // Choose the addend: whole word, or sign-extended offset byte
    always_comb begin
        if (sp_mode)
            addend = {{(WW-DW){b[DW-1]}}, b[DW-1:0]};
        else
            addend = b;
    end

    // Sum, the lower-part carry for H, and the flag byte
    always_comb begin
        full = {1'b0, a} + {1'b0, addend};
        part = {1'b0, a[HB-1:0]} + {1'b0, addend[HB-1:0]};
        res  = full[WW-1:0];
        fl   = {sp_mode ? 1'b0 : z_in, 1'b0, part[HB], full[WW], 4'b0000};
    end

endmodule

// File: rtl/nib_alu.sv
// Accumulator ALU top: routes the operation to the byte arithmetic unit,
// the bitwise unit or the wide adder, and registers result and flags when
// en is high. Synchronous active-low reset. Byte results are zero-extended.
module nib_alu
    import nib_alu_pkg::*;
#(
    parameter int DW = 8,
    parameter int WW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [3:0]      op,
    input  logic [WW-1:0]   opnd_a,
    input  logic [WW-1:0]   opnd_b,
    input  logic [7:0]      flags_in,
    output logic [WW-1:0]   result_q,
    output logic [7:0]      flags_q
);
    alu_op_e        op_e;
    logic [DW-1:0]  ar_res;
    logic [7:0]     ar_fl;
    logic [DW-1:0]  lg_res;
    logic [7:0]     lg_fl;
    logic [WW-1:0]  wd_res;
    logic [7:0]     wd_fl;
    logic [WW-1:0]  nxt_res;
    logic [7:0]     nxt_fl;

    assign op_e = alu_op_e'(op);

    nib_alu_arith8 #(.DW(DW)) u_arith (
        .op   (op_e),
        .a    (opnd_a[DW-1:0]),
        .b    (opnd_b[DW-1:0]),
        .c_in (flags_in[FL_C]),
        .res  (ar_res),
        .fl   (ar_fl)
    );

    nib_alu_logic8 #(.DW(DW)) u_logic (
        .op   (op_e),
        .a    (opnd_a[DW-1:0]),
        .b    (opnd_b[DW-1:0]),
        .z_in (flags_in[FL_Z]),
        .n_in (flags_in[FL_N]),
        .h_in (flags_in[FL_H]),
        .c_in (flags_in[FL_C]),
        .res  (lg_res),
        .fl   (lg_fl)
    );

    nib_alu_wide16 #(.DW(DW), .WW(WW)) u_wide (
        .sp_mode (op_e == OP_ADDSP),
        .a       (opnd_a),
        .b       (opnd_b),
        .z_in    (flags_in[FL_Z]),
        .res     (wd_res),
        .fl      (wd_fl)
    );

    // Pick the unit that owns this operation code
    always_comb begin
        unique case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_INC, OP_DEC: begin
                nxt_res = {{(WW-DW){1'b0}}, ar_res};
                nxt_fl  = ar_fl;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL, OP_SCF, OP_CCF: begin
                nxt_res = {{(WW-DW){1'b0}}, lg_res};
                nxt_fl  = lg_fl;
            end
            OP_ADDW, OP_ADDSP: begin
                nxt_res = wd_res;
                nxt_fl  = wd_fl;
            end
            default: begin
                nxt_res = opnd_a;
                nxt_fl  = flags_in & 8'hF0;
            end
        endcase
    end

    // Output registers, loaded on enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            flags_q  <= '0;
        end else if (en) begin
            result_q <= nxt_res;
            flags_q  <= nxt_fl;
        end
    end

endmodule

// File: rtl/nib_alu_chk.sv
// Property checker for the accumulator ALU, attached to every instance by bind.
module nib_alu_chk
    import nib_alu_pkg::*;
#(
    parameter int DW = 8,
    parameter int WW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [3:0]      op,
    input  logic [WW-1:0]   opnd_a,
    input  logic [7:0]      flags_in,
    input  logic [WW-1:0]   result_q,
    input  logic [7:0]      flags_q
);
    // R1: outputs hold while disabled
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(result_q) && $stable(flags_q)));

    // R3: compare leaves the accumulator value as result
    p_cmp_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_CMP) |=> (result_q == {{(WW-DW){1'b0}}, $past(opnd_a[DW-1:0])}));

    // R5: increment/decrement pass the carry through
    p_step_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == OP_INC || op == OP_DEC)) |=> (flags_q[FL_C] == $past(flags_in[FL_C])));

    // R6: bitwise ops clear N and C
    p_logic_nc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> (!flags_q[FL_N] && !flags_q[FL_C]));

    // R8: wide add keeps Z and clears N
    p_wide_z_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_ADDW) |=> (flags_q[FL_Z] == $past(flags_in[FL_Z]) && !flags_q[FL_N]));

    // R9: offset add clears Z and N
    p_offset_zn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_ADDSP) |=> (!flags_q[FL_Z] && !flags_q[FL_N]));

    // R10: low nibble of the flag byte is zero
    p_low_nibble_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[3:0] == 4'h0);

    // R11: byte operations zero the upper result byte
    p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op <= OP_CCF) |=> (result_q[WW-1:DW] == '0));

endmodule

bind nib_alu nib_alu_chk #(.DW(DW), .WW(WW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .op       (op),
    .opnd_a   (opnd_a),
    .flags_in (flags_in),
    .result_q (result_q),
    .flags_q  (flags_q)
);

// File: tb/sim_nib_alu.sv
// Scoreboard bench: the driver pushes model results, the monitor pops and compares.
module sim_nib_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [15:0] opnd_a = 16'h0;
    logic [15:0] opnd_b = 16'h0;
    logic [7:0]  flags_in = 8'h0;
    logic [15:0] result_q;
    logic [7:0]  flags_q;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [23:0] exp_q[$];
    string       tag_q[$];
    logic [23:0] last_out = 24'h0;
    logic        took;
    logic        rst_s;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    nib_alu u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .op       (op),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .flags_in (flags_in),
        .result_q (result_q),
        .flags_q  (flags_q)
    );

    // Expected result and flags written from the requirements
    function automatic logic [23:0] model(logic [3:0] o, logic [15:0] a, logic [15:0] b, logic [7:0] fi);
        logic [7:0]  bb;
        logic [7:0]  r8;
        logic [15:0] s;
        logic [15:0] r16;
        logic        z, n, h, c;
        z = fi[7]; n = fi[6]; h = fi[5]; c = fi[4];
        r16 = 16'h0;
        bb = b[7:0];
        if (o == 4'd1 || o == 4'd3) bb = b[7:0] + {7'd0, fi[4]};
        case (o)
            4'd0, 4'd1: begin
                r8 = a[7:0] + bb;
                h = (int'(a[3:0]) + int'(bb[3:0])) > 15;
                c = (int'(a[7:0]) + int'(bb)) > 255;
                n = 1'b0; z = (r8 == 0); r16 = {8'h0, r8};
            end
            4'd2, 4'd3, 4'd4: begin
                r8 = a[7:0] - bb;
                h = a[3:0] < bb[3:0];
                c = a[7:0] < bb;
                n = 1'b1; z = (r8 == 0);
                r16 = (o == 4'd4) ? {8'h0, a[7:0]} : {8'h0, r8};
            end
            4'd5: begin r8 = a[7:0] & b[7:0]; z = (r8 == 0); n = 0; h = 1; c = 0; r16 = {8'h0, r8}; end
            4'd6: begin r8 = a[7:0] | b[7:0]; z = (r8 == 0); n = 0; h = 0; c = 0; r16 = {8'h0, r8}; end
            4'd7: begin r8 = a[7:0] ^ b[7:0]; z = (r8 == 0); n = 0; h = 0; c = 0; r16 = {8'h0, r8}; end
            4'd8: begin r8 = a[7:0] + 8'd1; z = (r8 == 0); n = 0; h = (r8[3:0] == 4'h0); r16 = {8'h0, r8}; end
            4'd9: begin r8 = a[7:0] - 8'd1; z = (r8 == 0); n = 1; h = (r8[3:0] == 4'hF); r16 = {8'h0, r8}; end
            4'd10: begin r16 = {8'h0, ~a[7:0]}; n = 1; h = 1; end
            4'd11: begin r16 = {8'h0, a[7:0]}; n = 0; h = 0; c = 1; end
            4'd12: begin r16 = {8'h0, a[7:0]}; n = 0; h = 0; c = ~fi[4]; end
            4'd13, 4'd14: begin
                s = (o == 4'd14) ? {{8{b[7]}}, b[7:0]} : b;
                r16 = a + s;
                h = (int'(a[11:0]) + int'(s[11:0])) > 4095;
                c = (int'(a) + int'(s)) > 65535;
                n = 0;
                if (o == 4'd14) z = 0;
            end
            default: r16 = a;
        endcase
        return {r16, z, n, h, c, 4'b0000};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [23:0] act, input logic [23:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual res=%h fl=%h expected res=%h fl=%h",
                     tag, act[23:8], act[7:0], expv[23:8], expv[7:0]);
        end
    endtask

    // Driver: apply one enabled operation and push its expectation
    task automatic do_op(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b,
                         input logic [7:0] fi, input string tag);
        @(negedge clk);
        op = o; opnd_a = a; opnd_b = b; flags_in = fi; en = 1'b1;
        exp_q.push_back(model(o, a, b, fi));
        tag_q.push_back(tag);
    endtask

    // Disabled cycles with changing inputs (R1 hold)
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            en = 1'b0; op = 4'(i); opnd_a = 16'h5A5A + 16'(i); opnd_b = 16'hFFFF; flags_in = 8'hFF;
        end
    endtask

    // Monitor: compare after each edge
    always @(posedge clk) begin
        took  = en && rst_n;
        rst_s = rst_n;
        #1;
        if (!rst_s) begin
            last_out = 24'h0;
            check({result_q, flags_q} == 24'h0, "R1 reset", {result_q, flags_q}, 24'h0);
        end else if (took) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard empty", {result_q, flags_q}, 24'h0);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({result_q, flags_q} == e, t, {result_q, flags_q}, e);
                last_out = e;
            end
        end else begin
            check({result_q, flags_q} == last_out, "R1 hold", {result_q, flags_q}, last_out);
        end
    end

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 add
        do_op(4'd0, 16'h003A, 16'h00C6, 8'h00, "R2 add wrap to zero");
        do_op(4'd0, 16'h0008, 16'h0008, 8'h00, "R2 add half carry");
        do_op(4'd0, 16'h007F, 16'h0001, 8'hF0, "R2 add no carry");
        // R4 carry fold
        do_op(4'd1, 16'h0010, 16'h00FF, 8'h10, "R4 adc wrap of b");
        do_op(4'd1, 16'h000F, 16'h0000, 8'h10, "R4 adc carry in");
        do_op(4'd3, 16'h0010, 16'h000F, 8'h10, "R4 sbc carry in");
        do_op(4'd3, 16'h0033, 16'h00FF, 8'h10, "R4 sbc wrap of b");
        // R3 subtract and compare
        do_op(4'd2, 16'h0010, 16'h0001, 8'h00, "R3 sub nibble borrow");
        do_op(4'd2, 16'h0000, 16'h0001, 8'h00, "R3 sub full borrow");
        do_op(4'd4, 16'h0042, 16'h0042, 8'h00, "R3 cmp equal");
        do_op(4'd4, 16'h0020, 16'h0031, 8'h80, "R3 cmp less");
        // R5 step
        do_op(4'd8, 16'h00FF, 16'h0000, 8'h10, "R5 inc wrap keeps C");
        do_op(4'd8, 16'h0041, 16'h0000, 8'h00, "R5 inc plain");
        do_op(4'd9, 16'h0001, 16'h0000, 8'h00, "R5 dec to zero");
        do_op(4'd9, 16'h0000, 16'h0000, 8'h10, "R5 dec wrap");
        // R6 bitwise
        do_op(4'd5, 16'h00F0, 16'h000F, 8'h10, "R6 and zero");
        do_op(4'd6, 16'h0000, 16'h0000, 8'hF0, "R6 or zero");
        do_op(4'd7, 16'h00AA, 16'h0055, 8'h70, "R6 xor");
        // R7 flag ops
        do_op(4'd10, 16'h0035, 16'h0000, 8'h90, "R7 complement");
        do_op(4'd11, 16'h0077, 16'h0000, 8'h60, "R7 set carry");
        do_op(4'd12, 16'h0077, 16'h0000, 8'h90, "R7 complement carry set");
        do_op(4'd12, 16'h0077, 16'h0000, 8'h80, "R7 complement carry clear");
        // R8 wide add
        do_op(4'd13, 16'h0FFF, 16'h0001, 8'h80, "R8 wide half carry keeps Z");
        do_op(4'd13, 16'hFFFF, 16'h0001, 8'h00, "R8 wide carry");
        // R9 offset add
        do_op(4'd14, 16'h1000, 16'h00FF, 8'h80, "R9 negative offset");
        do_op(4'd14, 16'hFFF8, 16'h0008, 8'h80, "R9 positive wrap");
        do_op(4'd14, 16'h1234, 16'hAB10, 8'h00, "R9 upper b ignored");
        // R10 and R11
        do_op(4'd0, 16'h0001, 16'h0001, 8'h0F, "R10 low nibble ignored");
        do_op(4'd15, 16'hBEEF, 16'h1234, 8'hAF, "R11 pass");
        do_op(4'd6, 16'hFF12, 16'hEE01, 8'h00, "R11 upper byte zero");
        idle(4);
        // Random sweep with a noisy low flag nibble (R10)
        for (int i = 0; i < 400; i++) begin
            do_op(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom),
                  {4'($urandom), 4'($urandom_range(1, 15))}, "R10 random sweep");
            if (i % 50 == 49) idle(2);
        end
        idle(3);
        // Reset mid-stream (R1)
        @(negedge clk);
        rst_n = 1'b0; en = 1'b1; op = 4'd0; opnd_a = 16'h0001; opnd_b = 16'h0001;
        @(negedge clk);
        rst_n = 1'b1; en = 1'b0;
        idle(2);
        @(negedge clk);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule